// File: doc/BRIEF.md
# Register-Bank LIFO Stack

This block is a last-in-first-out store built from a bank of registers, by default 64 entries of 8 bits. A stack pointer names the top entry. An empty flag and a full flag describe the fill level, and each is updated in the same cycle as the operation that changes it. A client asserts `push_req` with a word on `din` to store that word. It asserts `pop_req` to take back the newest word, which appears on `dout`.

The pointer counts modulo the bank size. While the stack is empty, location 0 holds no valid data, so the first word goes to location 1. The last free slot is location 0 itself: the push that fills it takes the pointer back to zero and sets the full flag. A push while full and a pop while empty are refused, and each raises a one-cycle error pulse. A request that carries both push and pop is also refused. A refused request changes neither the pointer, the flags, the storage nor `dout`.

Top module: `regbank_lifo`

## Requirements
- R1: After synchronous reset `empty` is 1, and `full`, `ovf_err`, `udf_err` and `dout` are all 0.
- R2: Words come back from pops in the reverse of the order in which they were pushed.
- R3: After 63 accepted pushes from empty, `full` is still 0. The 64th accepted push sets `full` in the cycle after it is sampled.
- R4: A push while `full` is 1 raises `ovf_err` for exactly the following cycle. It leaves the flags and the stored words unchanged, so the pushed word is never returned.
- R5: A pop while `empty` is 1 raises `udf_err` for exactly the following cycle, and leaves `empty` at 1 and `dout` unchanged.
- R6: An accepted pop clears `full`. The pop that takes the pointer back to zero sets `empty`.
- R7: When push and pop are requested in the same cycle, neither is performed. Both `ovf_err` and `udf_err` pulse for the following cycle, and no state changes.
- R8: `dout` shows the word from the most recent accepted pop from the cycle after that pop, and holds it through idle and refused cycles.
- R9: The 64th word, which is stored at location 0, is the first word returned when popping from a full stack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| push_req | input | 1 | Request to store `din` on top of the stack |
| pop_req | input | 1 | Request to remove the top word |
| din | input | DATA_W | Word to store |
| dout | output | DATA_W | Most recently popped word |
| full | output | 1 | All entries hold data |
| empty | output | 1 | No entry holds data |
| ovf_err | output | 1 | One-cycle pulse: push refused |
| udf_err | output | 1 | One-cycle pulse: pop refused, or push and pop together |

## Verification
A push and a pop can be requested in the same cycle. The bench drives both request lines high for one cycle in two situations: with one word stored, and with an empty stack. The first case has a word on top that a wrongly granted pop would expose; the second has a free slot that a wrongly granted push would fill. The bench judges the result by seeing both error pulses, unchanged flags and an unchanged `dout`. It then pops the remaining word to confirm that the storage was left alone.

// File: rtl/lifo_pkg.sv
package lifo_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_PUSH  = 2'd1,
        OP_POP   = 2'd2,
        OP_CLASH = 2'd3
    } lifo_op_e;

    function automatic lifo_op_e classify_op(input logic push, input logic pop);
        lifo_op_e op;
        case ({pop, push})
            2'b01:   op = OP_PUSH;
            2'b10:   op = OP_POP;
            2'b11:   op = OP_CLASH;
            default: op = OP_IDLE;
        endcase
        return op;
    endfunction

endpackage

// File: rtl/lifo_bank.sv
module lifo_bank #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 64,
    parameter int PTR_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [PTR_W-1:0]  rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int FLAT_W = DATA_W * DEPTH;

    logic [FLAT_W-1:0] flat_q;

    for (genvar g = 0; g < DEPTH; g++) begin : gen_cell
        logic [DATA_W-1:0] cell_d;
        logic [DATA_W-1:0] cell_q;

        always_comb begin
            cell_d = cell_q;
            if (wr_en && (wr_addr == PTR_W'(g))) begin
                cell_d = wr_data;
            end
        end

        always_ff @(posedge clk) begin
            cell_q <= cell_d;
        end

        assign flat_q[g*DATA_W +: DATA_W] = cell_q;
    end

    assign rd_data = flat_q[rd_addr*DATA_W +: DATA_W];

endmodule

// File: rtl/lifo_ctrl.sv
module lifo_ctrl
    import lifo_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 64,
    parameter int PTR_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push_req,
    input  logic              pop_req,
    input  logic [DATA_W-1:0] top_data,
    output logic              wr_en,
    output logic [PTR_W-1:0]  wr_addr,
    output logic [PTR_W-1:0]  top_addr,
    output logic [DATA_W-1:0] dout,
    output logic              full,
    output logic              empty,
    output logic              ovf_err,
    output logic              udf_err
);
    localparam logic [PTR_W-1:0] PTR_ONE  = PTR_W'(1);
    localparam logic [PTR_W-1:0] PTR_ZERO = '0;

    typedef struct packed {
        logic [PTR_W-1:0]  ptr;
        logic              full;
        logic              empty;
        logic              ovf;
        logic              udf;
        logic [DATA_W-1:0] dout;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;
    lifo_op_e    op;
    logic        push_ok, pop_ok;
    logic [PTR_W-1:0] ptr_up, ptr_dn;

    always_comb begin
        op      = classify_op(push_req, pop_req);
        ptr_up  = st_q.ptr + PTR_ONE;
        ptr_dn  = st_q.ptr - PTR_ONE;
        push_ok = (op == OP_PUSH) && !st_q.full;
        pop_ok  = (op == OP_POP)  && !st_q.empty;

        st_d     = st_q;
        st_d.ovf = 1'b0;
        st_d.udf = 1'b0;

        unique case (op)
            OP_PUSH: begin
                if (push_ok) begin
                    st_d.ptr   = ptr_up;
                    st_d.empty = 1'b0;
                    st_d.full  = (ptr_up == PTR_ZERO);
                end else begin
                    st_d.ovf = 1'b1;
                end
            end
            OP_POP: begin
                if (pop_ok) begin
                    st_d.dout  = top_data;
                    st_d.ptr   = ptr_dn;
                    st_d.full  = 1'b0;
                    st_d.empty = (ptr_dn == PTR_ZERO);
                end else begin
                    st_d.udf = 1'b1;
                end
            end
            OP_CLASH: begin
                st_d.ovf = 1'b1;
                st_d.udf = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.ptr   <= PTR_ZERO;
            st_q.full  <= 1'b0;
            st_q.empty <= 1'b1;
            st_q.ovf   <= 1'b0;
            st_q.udf   <= 1'b0;
            st_q.dout  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_en    = push_ok;
    assign wr_addr  = ptr_up;
    assign top_addr = st_q.ptr;
    assign dout     = st_q.dout;
    assign full     = st_q.full;
    assign empty    = st_q.empty;
    assign ovf_err  = st_q.ovf;
    assign udf_err  = st_q.udf;

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(st_q.full && st_q.empty)); // R6
    AST_EMPTY_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        st_q.empty |-> (st_q.ptr == PTR_ZERO)); // R1
    AST_FULL_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        st_q.full |-> (st_q.ptr == PTR_ZERO)); // R3
    AST_PUSH_STEP: assert property (@(posedge clk) disable iff (rst)
        (push_req && !pop_req && !full) |=> (st_q.ptr == $past(st_q.ptr) + PTR_ONE) && !empty); // R3
    AST_POP_STEP: assert property (@(posedge clk) disable iff (rst)
        (pop_req && !push_req && !empty) |=> (st_q.ptr == $past(st_q.ptr) - PTR_ONE) && !full); // R6
    AST_NO_OVERFLOW_WRITE: assert property (@(posedge clk) disable iff (rst)
        (push_req && full) |-> !wr_en); // R4
    AST_OVERFLOW_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (push_req && full) |=> ovf_err && full && $stable(st_q.ptr)); // R4
    AST_UNDERFLOW_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (pop_req && empty) |=> udf_err && empty && $stable(dout)); // R5
    AST_CLASH_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (push_req && pop_req) |=> ovf_err && udf_err && $stable(st_q.ptr) && $stable(dout)); // R7
    AST_DOUT_HELD: assert property (@(posedge clk) disable iff (rst)
        !(pop_req && !push_req && !empty) |=> $stable(dout)); // R8

endmodule

// File: rtl/regbank_lifo.sv
module regbank_lifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push_req,
    input  logic              pop_req,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              full,
    output logic              empty,
    output logic              ovf_err,
    output logic              udf_err
);
    localparam int PTR_W = $clog2(DEPTH);

    logic              wr_en;
    logic [PTR_W-1:0]  wr_addr;
    logic [PTR_W-1:0]  top_addr;
    logic [DATA_W-1:0] top_data;

    lifo_ctrl #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH),
        .PTR_W  (PTR_W)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .push_req (push_req),
        .pop_req  (pop_req),
        .top_data (top_data),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .top_addr (top_addr),
        .dout     (dout),
        .full     (full),
        .empty    (empty),
        .ovf_err  (ovf_err),
        .udf_err  (udf_err)
    );

    lifo_bank #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH),
        .PTR_W  (PTR_W)
    ) u_bank (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (din),
        .rd_addr (top_addr),
        .rd_data (top_data)
    );

    AST_ERR_NEEDS_REQUEST: assert property (@(posedge clk) disable iff (rst)
        !(push_req || pop_req) |=> !ovf_err && !udf_err); // R4

endmodule

// File: tb/tb_regbank_lifo.sv
module tb_regbank_lifo;
    localparam int DATA_W = 8;
    localparam int DEPTH  = 64;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              push_req = 1'b0;
    logic              pop_req = 1'b0;
    logic [DATA_W-1:0] din = '0;
    logic [DATA_W-1:0] dout;
    logic              full, empty, ovf_err, udf_err;

    always #4 clk = ~clk;

    regbank_lifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst), .push_req(push_req), .pop_req(pop_req),
        .din(din), .dout(dout), .full(full), .empty(empty),
        .ovf_err(ovf_err), .udf_err(udf_err)
    );

    typedef struct {
        logic [DATA_W-1:0] dout;
        logic full, empty, ovf, udf;
        string tag;
    } exp_t;

    exp_t              exp_q[$];
    logic [DATA_W-1:0] model[$];
    logic [DATA_W-1:0] m_dout = '0;
    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Monitor: compares every queued expectation at the falling edge.
    always @(negedge clk) begin
        while (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (dout !== e.dout || full !== e.full || empty !== e.empty ||
                ovf_err !== e.ovf || udf_err !== e.udf) begin
                fails++;
                $display("FAIL %s: got dout=%0h full=%0b empty=%0b ovf=%0b udf=%0b, expected dout=%0h full=%0b empty=%0b ovf=%0b udf=%0b",
                         e.tag, dout, full, empty, ovf_err, udf_err,
                         e.dout, e.full, e.empty, e.ovf, e.udf);
            end
        end
    end

    task automatic expect_now(input bit ovf, input bit udf, input string tag);
        exp_t e;
        e.dout  = m_dout;
        e.full  = (model.size() == DEPTH);
        e.empty = (model.size() == 0);
        e.ovf   = ovf;
        e.udf   = udf;
        e.tag   = tag;
        exp_q.push_back(e);
    endtask

    // Driver: applies one request cycle and queues the expected outcome.
    task automatic drive(input bit p, input bit q, input logic [DATA_W-1:0] d, input string tag);
        bit ovf = 0, udf = 0;
        @(negedge clk);
        push_req = p; pop_req = q; din = d;
        @(posedge clk);
        #1;
        push_req = 0; pop_req = 0;
        if (p && q) begin
            ovf = 1; udf = 1;
        end else if (p) begin
            if (model.size() == DEPTH) ovf = 1;
            else model.push_back(d);
        end else if (q) begin
            if (model.size() == 0) udf = 1;
            else m_dout = model.pop_back();
        end
        expect_now(ovf, udf, tag);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        expect_now(0, 0, "R1 reset state");

        // R2 / R8: short LIFO ordering, dout held over idle cycles
        drive(1, 0, 8'h11, "R2 push");
        drive(1, 0, 8'h22, "R2 push");
        drive(1, 0, 8'h33, "R2 push");
        drive(0, 1, 0, "R2 pop newest");
        drive(0, 0, 0, "R8 hold idle");
        drive(0, 1, 0, "R2 pop middle");
        drive(0, 1, 0, "R6 pop to empty");
        drive(0, 0, 0, "R8 hold idle");

        // R5: pops while empty
        drive(0, 1, 0, "R5 underflow");
        drive(0, 1, 0, "R5 underflow again");
        drive(0, 0, 0, "R5 pulse clears");

        // R7: clash with one word stored, then with empty stack
        drive(1, 0, 8'hA5, "R7 setup push");
        drive(1, 1, 8'h5A, "R7 clash with data");
        drive(0, 0, 0, "R7 pulse clears");
        drive(0, 1, 0, "R7 storage intact");
        drive(1, 1, 8'h77, "R7 clash when empty");
        drive(0, 0, 0, "R8 hold after clash");

        // R3: fill to 63, then the 64th sets full
        for (int i = 0; i < DEPTH - 1; i++)
            drive(1, 0, 8'(i * 7 + 3), "R3 fill");
        drive(1, 0, 8'hE1, "R3 64th push sets full");

        // R4: overflow leaves storage alone
        drive(1, 0, 8'hFF, "R4 overflow");
        drive(1, 0, 8'hFE, "R4 overflow again");
        drive(0, 0, 0, "R4 pulse clears");

        // R9: location 0 word comes first; refill and drain completely
        drive(0, 1, 0, "R9 pop location 0 word");
        drive(1, 0, 8'hC3, "R3 refill to full");
        for (int i = 0; i < DEPTH; i++)
            drive(0, 1, 0, "R6 drain");
        drive(0, 1, 0, "R5 underflow after drain");
        drive(0, 0, 0, "R8 final hold");

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule